// File: doc/BRIEF.md
# Character LCD Byte Writer

This block takes bytes from a processor-side write link and delivers them to a character LCD that is wired in 4-bit mode. Each byte, together with a register-select bit that marks it as a command or as character data, is latched on a single-cycle write strobe. The block then sends it to the display as two nibbles, each with its own enable pulse, and waits out the display's execution time before it takes the next byte.

The `busy` output is a level flag. It is high whenever a byte cannot be taken, including the whole power-up phase, during which the block sets the display up by itself. A producer such as a FIFO port or a processor stream link may therefore fire a one-cycle strobe whenever `busy` is low, with no request/acknowledge exchange.

All timing (setup before enable, enable width, per-byte wait, per-nibble wait during start-up and the power-on delay) is given as cycle-count parameters.

Top module: `lcd_nibble_writer`

## Requirements
- R1: `busy` is high from reset until the start-up sequence has finished, and no byte is accepted before then.
- R2: After `PWR_WAIT_CYC` cycles, the start-up sequence issues four lone nibbles 0x3, 0x3, 0x3, 0x2, each followed by `NIB_WAIT_CYC` cycles. It then sends the command bytes 0x28, 0x0C, 0x06, 0x01. Everything in this sequence is sent with `lcd_rs` low.
- R3: When `wr_stb` is high and `busy` is low, `wr_data` and `wr_rs` are captured at that edge and `busy` is high in the next cycle. The input data may change right after the strobe.
- R4: A byte appears on `lcd_db[3:0]` as its bits 7:4 first and then its bits 3:0, with one enable pulse for each nibble. `lcd_rs` equals the captured `wr_rs`.
- R5: Before `lcd_en` rises, `lcd_db` and `lcd_rs` hold their values for at least `SETUP_CYC` cycles with enable low. Both stay constant while enable is high.
- R6: Every enable pulse lasts exactly `PULSE_CYC` cycles.
- R7: After the last enable pulse of a byte falls, `busy` stays high for exactly `BYTE_WAIT_CYC` cycles before it drops.
- R8: A strobe given while `busy` is high is ignored. It produces no enable pulse and changes no data sent afterwards.
- R9: `lcd_rw` is low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 8 | Byte to send |
| wr_rs | input | 1 | Register select for the byte (1 = character data, 0 = command) |
| wr_stb | input | 1 | One-cycle write strobe |
| busy | output | 1 | High while a byte cannot be accepted |
| lcd_db | output | 4 | LCD data nibble |
| lcd_en | output | 1 | LCD enable |
| lcd_rs | output | 1 | LCD register select |
| lcd_rw | output | 1 | LCD read/write, always low |

## Verification
The hardest case to reach from the ports is a strobe that arrives while a transfer is still running. It has to be shown that the strobe leaves no trace, which means no extra pulse and no corruption of a later byte. The driver fires a stray strobe with a distinctive byte a few cycles after a real write, pushing nothing into the expected queue. Any effect of that strobe would surface either as a mismatch when the scoreboard compares nibbles or as an unexpected pulse arriving when the queue is empty. The byte-final wait is measured by counting the cycles between the last falling edge of enable and the fall of `busy`.

// File: rtl/lcd_nibble_writer.sv
module lcd_nibble_writer #(
  parameter int SETUP_CYC     = 4,
  parameter int PULSE_CYC     = 40,
  parameter int BYTE_WAIT_CYC = 5000,
  parameter int NIB_WAIT_CYC  = 625000,
  parameter int PWR_WAIT_CYC  = 2000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] wr_data,
  input  logic       wr_rs,
  input  logic       wr_stb,
  output logic       busy,
  output logic [3:0] lcd_db,
  output logic       lcd_en,
  output logic       lcd_rs,
  output logic       lcd_rw
);
  localparam int M1 = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int M2 = (BYTE_WAIT_CYC > NIB_WAIT_CYC) ? BYTE_WAIT_CYC : NIB_WAIT_CYC;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > PWR_WAIT_CYC) ? M3 : PWR_WAIT_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_END = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PULSE_END = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] BYTE_END  = CW'(BYTE_WAIT_CYC - 1);
  localparam logic [CW-1:0] NIB_END   = CW'(NIB_WAIT_CYC - 1);
  localparam logic [CW-1:0] PWR_END   = CW'(PWR_WAIT_CYC - 1);
  localparam logic [2:0]    LAST_STEP = 3'd7;

  typedef enum logic [2:0] {S_PWR, S_SETUP, S_PULSE, S_GAP, S_IDLE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    step;
  logic          ready, single, lo, rs_q;
  logic [7:0]    byte_q;

  function automatic logic [8:0] init_item(input logic [2:0] s);
    case (s)
      3'd0, 3'd1, 3'd2: init_item = {1'b1, 8'h30};
      3'd3:             init_item = {1'b1, 8'h20};
      3'd4:             init_item = {1'b0, 8'h28};
      3'd5:             init_item = {1'b0, 8'h0C};
      3'd6:             init_item = {1'b0, 8'h06};
      default:          init_item = {1'b0, 8'h01};
    endcase
  endfunction

  wire [CW-1:0] gap_end = single ? NIB_END : BYTE_END;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_PWR; cnt <= '0; step <= '0; ready <= 1'b0;
      single <= 1'b0; lo <= 1'b0; rs_q <= 1'b0; byte_q <= '0;
    end else begin
      case (st)
        S_PWR:
          if (cnt == PWR_END) begin
            {single, byte_q} <= init_item(step);
            rs_q <= 1'b0; lo <= 1'b0; cnt <= '0; st <= S_SETUP;
          end else cnt <= cnt + 1'b1;
        S_SETUP:
          if (cnt == SETUP_END) begin
            cnt <= '0; st <= S_PULSE;
          end else cnt <= cnt + 1'b1;
        S_PULSE:
          if (cnt == PULSE_END) begin
            cnt <= '0;
            if (!single && !lo) begin
              lo <= 1'b1; st <= S_SETUP;
            end else st <= S_GAP;
          end else cnt <= cnt + 1'b1;
        S_GAP:
          if (cnt == gap_end) begin
            cnt <= '0;
            if (ready) st <= S_IDLE;
            else if (step == LAST_STEP) begin
              ready <= 1'b1; st <= S_IDLE;
            end else begin
              step <= step + 1'b1;
              {single, byte_q} <= init_item(step + 1'b1);
              rs_q <= 1'b0; lo <= 1'b0; st <= S_SETUP;
            end
          end else cnt <= cnt + 1'b1;
        default:
          if (wr_stb) begin
            byte_q <= wr_data; rs_q <= wr_rs;
            single <= 1'b0; lo <= 1'b0; cnt <= '0; st <= S_SETUP;
          end
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign lcd_en = (st == S_PULSE);
  assign lcd_db = lo ? byte_q[3:0] : byte_q[7:4];
  assign lcd_rs = rs_q;
  assign lcd_rw = 1'b0;
endmodule

module lcd_nibble_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic       busy,
  input logic [3:0] lcd_db,
  input logic       lcd_en,
  input logic       lcd_rs,
  input logic       lcd_rw
);
  assert_rw_low_R9: assert property (@(posedge clk) disable iff (!rst_n) !lcd_rw);
  assert_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !busy) |=> busy);
  assert_setup_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en) |-> ($stable(lcd_db) && $stable(lcd_rs)));
  assert_pulse_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |=> (!lcd_en || ($stable(lcd_db) && $stable(lcd_rs))));
  assert_en_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |-> busy);
  assert_busy_after_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_en) |-> busy);
endmodule

bind lcd_nibble_writer lcd_nibble_writer_chk chk_i (.*);

// File: tb/lcd_nibble_writer_tb_top.sv
module lcd_nibble_writer_tb_top;
  localparam int SU = 2, PW = 4, BW = 20, NW = 30, PWR = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_rs = 1'b0, wr_stb = 1'b0;
  logic busy, lcd_en, lcd_rs, lcd_rw;
  logic [3:0] lcd_db;

  always #4 clk = ~clk;

  lcd_nibble_writer #(.SETUP_CYC(SU), .PULSE_CYC(PW), .BYTE_WAIT_CYC(BW),
    .NIB_WAIT_CYC(NW), .PWR_WAIT_CYC(PWR)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_rs(wr_rs), .wr_stb(wr_stb),
    .busy(busy), .lcd_db(lcd_db), .lcd_en(lcd_en), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw));

  int checks = 0, errors = 0, pulses = 0;
  logic [4:0] expq[$];
  bit rw_bad = 0, done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] d, input logic rs);
    expq.push_back({rs, d[7:4]});
    expq.push_back({rs, d[3:0]});
  endtask

  task automatic write_byte(input logic [7:0] d, input logic rs);
    while (busy) @(negedge clk);
    push_byte(d, rs);
    wr_data = d; wr_rs = rs; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; wr_data = ~d; wr_rs = ~rs;
    chk(busy == 1'b1, "R3 busy after strobe", busy, 1);
  endtask

  // monitor / scoreboard
  logic prev_en = 0, prev_rs = 0;
  logic [3:0] prev_db = 0;
  int stable_cnt = 0, hi_cnt = 0, lb_cnt = 0;
  bit armed = 0, first_idle = 1;
  always @(negedge clk) if (rst_n && !done) begin
    if (lcd_rw) rw_bad = 1;
    if (lcd_db != prev_db || lcd_rs != prev_rs) stable_cnt = 1; else stable_cnt++;
    if (lcd_en && !prev_en) begin
      logic [4:0] e;
      pulses++;
      if (expq.size() == 0) chk(0, "R8 unexpected pulse", {lcd_rs, lcd_db}, 0);
      else begin
        e = expq.pop_front();
        chk({lcd_rs, lcd_db} == e, "R4 nibble/rs", {lcd_rs, lcd_db}, e);
      end
      chk(stable_cnt > SU, "R5 setup", stable_cnt - 1, SU);
      hi_cnt = 1;
    end else if (lcd_en) begin
      hi_cnt++;
      if (lcd_db != prev_db) chk(0, "R5 held during pulse", lcd_db, prev_db);
    end
    if (!lcd_en && prev_en) begin
      chk(hi_cnt == PW, "R6 pulse width", hi_cnt, PW);
      armed = 1; lb_cnt = 0;
    end
    if (armed && !lcd_en) begin
      if (busy) lb_cnt++;
      else begin
        chk(lb_cnt == BW, "R7 byte wait", lb_cnt, BW);
        armed = 0;
        if (first_idle) begin
          chk(pulses == 12, "R1 R2 init pulses before idle", pulses, 12);
          first_idle = 0;
        end
      end
    end
    prev_en = lcd_en; prev_db = lcd_db; prev_rs = lcd_rs;
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R2 start-up sequence
    for (int i = 0; i < 3; i++) expq.push_back(5'h03);
    expq.push_back(5'h02);
    push_byte(8'h28, 0); push_byte(8'h0C, 0); push_byte(8'h06, 0); push_byte(8'h01, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after reset", busy, 1);
    chk(lcd_en == 1'b0, "R1 enable low after reset", lcd_en, 0);
    // R1: strobe during start-up ignored
    repeat (10) @(negedge clk);
    wr_data = 8'hEE; wr_rs = 1'b1; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    write_byte(8'h41, 1);
    // R8: stray strobe while busy
    repeat (3) @(negedge clk);
    wr_data = 8'h99; wr_rs = 1'b0; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    write_byte(8'hA5, 1);
    write_byte(8'h80, 0);
    write_byte(8'hFF, 1);
    write_byte(8'h00, 0);
    write_byte(8'h5A, 1);
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R8 all expected nibbles seen", expq.size(), 0);
    chk(pulses == 24, "R8 total pulse count", pulses, 24);
    chk(!rw_bad, "R9 rw low", rw_bad, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule